// File: doc/BRIEF.md
# Dual-Buffer Receive Frame Controller

This block takes frames from a byte-wide stream (valid, data, end-of-frame marker) and writes each one into one of two 2 KB receive buffers, called ping and pong. Once the final byte of a frame is stored, the block raises a per-buffer done flag. From then on, software owns that buffer. The hardware will not write into it again until software clears the flag through the buffer's status word. Frames go to the buffers in strict alternation: ping, pong, ping, and so on. A frame whose target buffer is still owned by software is thrown away as a whole, and the fill pointer stays where it was.

Software reads the buffers over a simple word-wide memory-mapped port. Ping data starts at 0x1000 and ping status is at 0x17FC. Pong data starts at 0x1800 and pong status is at 0x1FFC. Bytes are packed little-endian into 32-bit words. Each buffer's status word also holds an interrupt enable, and a level interrupt is raised while any enabled buffer is done. A build parameter removes the pong buffer, so that every frame is steered to ping.

Top module: `rxpp_frame_rx`

## Requirements
- R1: After reset, both status words read zero, `irq` is low, and the first stored frame goes to the ping buffer.
- R2: Byte k of a stored frame lands in word k/4 of its buffer, in byte lane k mod 4 (lane 0 = bits 7:0). `bus_rdata` presents the word addressed in the previous cycle. Status bit 0 (done) reads 1 from the cycle after the frame's last byte.
- R3: In the word that holds a frame's final bytes, the lanes above the last byte read as zero.
- R4: With the pong buffer present, stored frames alternate between ping and pong, starting with ping.
- R5: A frame that starts while its target buffer's done flag is 1 is dropped entirely. That buffer's data and status do not change, and the next frame goes to the same target.
- R6: Writing a status word with bit 0 = 0 clears that buffer's done flag, and writing bit 0 = 1 leaves it unchanged. Bit 3 is a read/write interrupt enable. All other status bits read 0.
- R7: `irq` is high exactly while some buffer has both done and its enable (bit 3) set.
- R8: A frame longer than 2044 bytes keeps its first 2044 bytes, in words 0 to 510. The excess is discarded, done is still set, and the status word is not disturbed.
- R9: With `PONG_EN` = 0, every frame goes to ping. The pong region, status included, reads zero and ignores writes.
- R10: When a frame completes in the same cycle as a software write of done = 0 to that buffer's status, the flag ends up set.
- R11: Bus writes to buffer data words have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A stream byte is present this cycle |
| rx_byte | input | 8 | Stream byte |
| rx_last | input | 1 | This byte ends the frame |
| bus_addr | input | 13 | Byte address of the word accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| irq | output | 1 | Level interrupt |

## Verification
Two events can fall in the same clock edge: a frame ending, which sets its buffer's done flag, and a software write of zero to that same status word. The bench provokes this by driving the status write together with the frame's final byte. It judges the outcome by reading the status back and by comparing against the reference model every cycle; the flag must be set. A similar race exists between a frame's first byte and a clear of its target buffer. That start is judged against the flag as it stood before the edge.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int BUF_BYTES  = 2048;
    localparam int BUF_WORDS  = BUF_BYTES / WORD_BYTES;
    localparam int IDX_W      = $clog2(BUF_WORDS);
    localparam int DATA_WORDS = BUF_WORDS - 1;          // last word is the status slot
    localparam int CAP_BYTES  = DATA_WORDS * WORD_BYTES;
    localparam int CNT_W      = $clog2(CAP_BYTES + 1);
    localparam int BANK_BIT   = $clog2(BUF_BYTES);      // selects ping / pong
    localparam int REGION_BIT = BANK_BIT + 1;           // selects the receive window
    localparam int MAP_W      = REGION_BIT + 1;
    localparam int DONE_BIT   = 0;
    localparam int IE_BIT     = 3;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_KEEP,
        FR_SKIP
    } fr_mode_e;

    typedef struct packed {
        logic              en;
        logic              bank;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } word_wr_t;

    // Place a byte into a lane; a fresh word starts from zero so that
    // unused upper lanes of a trailing word read as zero.
    function automatic logic [WORD_W-1:0] lane_put(
        input logic [WORD_W-1:0] acc,
        input logic [LANE_W-1:0] lane,
        input logic [7:0]        b
    );
        logic [WORD_W-1:0] r;
        r = (lane == '0) ? '0 : acc;
        r[lane*8 +: 8] = b;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] stat_word(input logic done, input logic ie);
        logic [WORD_W-1:0] r;
        r = '0;
        r[DONE_BIT] = done;
        r[IE_BIT]   = ie;
        return r;
    endfunction

endpackage

// File: rtl/rxpp_packer.sv
module rxpp_packer
    import rxpp_pkg::*;
#(
    parameter bit DUAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    input  logic [1:0] busy,
    output word_wr_t   wr,
    output logic       fin,
    output logic       fin_bank
);

    fr_mode_e          mode;
    logic              tgt;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] acc;

    logic              take;
    logic              room;
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] acc_n;

    always_comb begin
        take  = in_valid && ((mode == FR_KEEP) || ((mode == FR_IDLE) && !busy[tgt]));
        room  = cnt < CNT_W'(CAP_BYTES);
        lane  = cnt[LANE_W-1:0];
        acc_n = lane_put(acc, lane, in_byte);

        wr.en   = take && room && ((lane == LANE_W'(WORD_BYTES - 1)) || in_last);
        wr.bank = tgt;
        wr.idx  = IDX_W'(cnt >> LANE_W);
        wr.data = acc_n;

        fin      = take && in_last;
        fin_bank = tgt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= FR_IDLE;
            tgt  <= 1'b0;
            cnt  <= '0;
            acc  <= '0;
        end else if (take) begin
            if (room) begin
                cnt <= cnt + 1'b1;
                acc <= acc_n;
            end
            if (in_last) begin
                mode <= FR_IDLE;
                cnt  <= '0;
                tgt  <= DUAL ? ~tgt : 1'b0;
            end else begin
                mode <= FR_KEEP;
            end
        end else if (in_valid) begin
            if ((mode == FR_IDLE) && !in_last)
                mode <= FR_SKIP;
            else if ((mode == FR_SKIP) && in_last)
                mode <= FR_IDLE;
        end
    end

    // R5: a buffer owned by software is never written
    a_r5_owned_untouched: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> !busy[wr.bank]);

    // R8: truncation never reaches the status slot
    a_r8_status_slot_safe: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.idx < IDX_W'(DATA_WORDS)));

endmodule

// File: rtl/rxpp_bank.sv
module rxpp_bank
    import rxpp_pkg::*;
#(
    parameter bit BANK_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  word_wr_t          wr,
    input  logic              set_done,
    input  logic              st_we,
    input  logic              st_done_w,
    input  logic              st_ie_w,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              done,
    output logic              ie
);

    logic [WORD_W-1:0] mem [BUF_WORDS];

    always_ff @(posedge clk) begin
        if (wr.en && (wr.bank == BANK_ID))
            mem[wr.idx] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rd_idx == IDX_W'(DATA_WORDS))
            rd_word <= stat_word(done, ie);
        else
            rd_word <= mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            ie   <= 1'b0;
        end else begin
            if (st_we) begin
                ie <= st_ie_w;
                if (!st_done_w)
                    done <= 1'b0;
            end
            if (set_done)
                done <= 1'b1;
        end
    end

    // R6: only the hardware can raise the done flag
    a_r6_done_only_by_hw: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(set_done));

    // R10: frame completion wins over a concurrent software clear
    a_r10_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_done |=> done);

endmodule

// File: rtl/rxpp_frame_rx.sv
module rxpp_frame_rx
    import rxpp_pkg::*;
#(
    parameter bit PONG_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    input  logic [MAP_W-1:0]  bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    logic             in_rx;
    logic             sel_bank;
    logic [IDX_W-1:0] widx;
    logic             is_stat;
    logic             st_we_ping;
    logic             st_we_pong;

    assign in_rx      = bus_addr[REGION_BIT];
    assign sel_bank   = bus_addr[BANK_BIT];
    assign widx       = bus_addr[BANK_BIT-1:LANE_W];
    assign is_stat    = (widx == IDX_W'(DATA_WORDS));
    assign st_we_ping = bus_we && in_rx && is_stat && !sel_bank;
    assign st_we_pong = bus_we && in_rx && is_stat && sel_bank;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[LANE_W-1:0], bus_wdata[WORD_W-1:IE_BIT+1],
                           bus_wdata[IE_BIT-1:DONE_BIT+1]};

    word_wr_t          wr;
    logic              fin;
    logic              fin_bank;
    logic              ping_done, ping_ie, pong_done, pong_ie;
    logic [WORD_W-1:0] ping_rd, pong_rd;

    rxpp_packer #(.DUAL(PONG_EN)) u_packer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_byte  (rx_byte),
        .in_last  (rx_last),
        .busy     ({pong_done, ping_done}),
        .wr       (wr),
        .fin      (fin),
        .fin_bank (fin_bank)
    );

    rxpp_bank #(.BANK_ID(1'b0)) u_ping (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .set_done  (fin && !fin_bank),
        .st_we     (st_we_ping),
        .st_done_w (bus_wdata[DONE_BIT]),
        .st_ie_w   (bus_wdata[IE_BIT]),
        .rd_idx    (widx),
        .rd_word   (ping_rd),
        .done      (ping_done),
        .ie        (ping_ie)
    );

    if (PONG_EN) begin : g_pong
        rxpp_bank #(.BANK_ID(1'b1)) u_pong (
            .clk       (clk),
            .rst       (rst),
            .wr        (wr),
            .set_done  (fin && fin_bank),
            .st_we     (st_we_pong),
            .st_done_w (bus_wdata[DONE_BIT]),
            .st_ie_w   (bus_wdata[IE_BIT]),
            .rd_idx    (widx),
            .rd_word   (pong_rd),
            .done      (pong_done),
            .ie        (pong_ie)
        );

        logic prev_bank;
        logic have_prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_bank <= 1'b0;
                have_prev <= 1'b0;
            end else if (fin) begin
                prev_bank <= fin_bank;
                have_prev <= 1'b1;
            end
        end

        // R4: consecutive stored frames use opposite buffers
        a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
            (fin && have_prev) |-> (fin_bank != prev_bank));
    end else begin : g_single
        assign pong_rd   = '0;
        assign pong_done = 1'b0;
        assign pong_ie   = 1'b0;

        logic unused_pong_we;
        assign unused_pong_we = st_we_pong;

        // R9: without the pong buffer every frame lands in ping
        a_r9_ping_only: assert property (@(posedge clk) disable iff (rst)
            fin |-> !fin_bank);
    end

    logic rd_region_q;
    logic rd_bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_region_q <= 1'b0;
            rd_bank_q   <= 1'b0;
        end else begin
            rd_region_q <= in_rx;
            rd_bank_q   <= sel_bank;
        end
    end

    assign bus_rdata = !rd_region_q ? '0 : (rd_bank_q ? pong_rd : ping_rd);
    assign irq       = (ping_done && ping_ie) || (pong_done && pong_ie);

endmodule

// File: tb/rxpp_frame_rx_test.sv
module rxpp_frame_rx_test;

    localparam time CLK = 4ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'd0;
    logic        rx_last = 1'b0;
    logic [12:0] bus_addr = 13'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata, bus_rdata_s;
    logic        irq, irq_s;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    always #(CLK / 2) clk = ~clk;

    rxpp_frame_rx uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    rxpp_frame_rx #(.PONG_EN(1'b0)) uut_single (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata_s), .irq(irq_s)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int i);
        return 8'(seed * 37 + i * 11 + 1);
    endfunction

    function automatic logic [31:0] wexp(input int seed, input int n, input int w);
        logic [31:0] r;
        r = 32'd0;
        for (int k = 0; k < 4; k++)
            if (w * 4 + k < n) r[k*8 +: 8] = bval(seed, w * 4 + k);
        return r;
    endfunction

    // ---------------- reference model ----------------
    logic [7:0]  m_mem [2][2048];
    bit          m_done [2];
    bit          m_ie [2];
    int          m_tgt;
    int          m_state;
    logic [7:0]  m_q [$];
    logic [31:0] m_rdata;
    bit          m_irq;
    bit          m_fin;
    int          m_fb;
    int          m_b, m_w;

    task automatic model_commit();
        int n;
        n = m_q.size();
        for (int i = 0; i < n && i < 2044; i++) m_mem[m_tgt][i] = m_q[i];
        for (int i = n; (i % 4) != 0 && i < 2044; i++) m_mem[m_tgt][i] = 8'd0;
        m_fin = 1'b1;
        m_fb  = m_tgt;
        m_tgt = 1 - m_tgt;
        m_state = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_done[0] = 0; m_done[1] = 0; m_ie[0] = 0; m_ie[1] = 0;
            m_tgt = 0; m_state = 0; m_q.delete(); m_rdata = 32'd0; m_irq = 0;
        end else begin
            if (!bus_addr[12]) m_rdata = 32'd0;
            else begin
                m_b = int'(bus_addr[11]);
                m_w = int'(bus_addr[10:2]);
                if (m_w == 511) m_rdata = {28'd0, m_ie[m_b], 2'b00, m_done[m_b]};
                else m_rdata = {m_mem[m_b][m_w*4+3], m_mem[m_b][m_w*4+2],
                                m_mem[m_b][m_w*4+1], m_mem[m_b][m_w*4]};
            end
            m_fin = 1'b0;
            if (rx_valid) begin
                case (m_state)
                    0: if (m_done[m_tgt]) m_state = rx_last ? 0 : 2;
                       else begin
                           m_q.delete();
                           m_q.push_back(rx_byte);
                           if (rx_last) model_commit(); else m_state = 1;
                       end
                    1: begin
                           m_q.push_back(rx_byte);
                           if (rx_last) model_commit();
                       end
                    default: if (rx_last) m_state = 0;
                endcase
            end
            if (bus_we && bus_addr[12] && (bus_addr[10:2] == 9'd511)) begin
                m_b = int'(bus_addr[11]);
                m_ie[m_b] = bus_wdata[3];
                if (!bus_wdata[0]) m_done[m_b] = 0;
            end
            if (m_fin) m_done[m_fb] = 1;
            m_irq = (m_done[0] && m_ie[0]) || (m_done[1] && m_ie[1]);
        end
    end

    always @(negedge clk) begin
        if (started && !rst) begin
            chk(irq === m_irq, "R7 irq vs model", {31'd0, irq}, {31'd0, m_irq});
            chk(bus_rdata === m_rdata, "R2 rdata vs model", bus_rdata, m_rdata);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_frame(input int n, input int seed);
        bus_addr = 13'd0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_byte  = bval(seed, i);
            rx_last  = (i == n - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 13'd0;
    endtask

    task automatic bus_read(input logic [12:0] a, output logic [31:0] d, output logic [31:0] ds);
        bus_addr = a;
        @(negedge clk);
        d  = bus_rdata;
        ds = bus_rdata_s;
        bus_addr = 13'd0;
    endtask

    localparam logic [12:0] PING = 13'h1000, PING_ST = 13'h17FC;
    localparam logic [12:0] PONG = 13'h1800, PONG_ST = 13'h1FFC;

    initial begin : watchdog
        #(CLK * 200000);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d, ds;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(PING_ST, d, ds); chk(d == 32'd0, "R1 ping status", d, 32'd0);
        bus_read(PONG_ST, d, ds); chk(d == 32'd0, "R1 pong status", d, 32'd0);
        chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);

        // R2 / R1: first frame goes to ping
        send_frame(8, 1);
        bus_read(PING, d, ds);          chk(d == wexp(1, 8, 0), "R2 ping word0", d, wexp(1, 8, 0));
        bus_read(PING + 13'd4, d, ds);  chk(d == wexp(1, 8, 1), "R2 ping word1", d, wexp(1, 8, 1));
        bus_read(PING_ST, d, ds);       chk(d == 32'd1, "R2 ping done", d, 32'd1);

        // R4 / R3: second frame goes to pong, partial last word
        send_frame(6, 2);
        bus_read(PONG_ST, d, ds);       chk(d == 32'd1, "R4 pong done", d, 32'd1);
        chk(ds == 32'd0, "R9 single pong status", ds, 32'd0);
        bus_read(PONG + 13'd4, d, ds);  chk(d == wexp(2, 6, 1), "R3 pong partial word", d, wexp(2, 6, 1));
        chk(ds == 32'd0, "R9 single pong data", ds, 32'd0);
        bus_read(PING, d, ds);          chk(ds == wexp(1, 8, 0), "R9 single ping kept", ds, wexp(1, 8, 0));

        // R5: both owned, frame dropped
        send_frame(5, 9);
        bus_read(PING, d, ds);          chk(d == wexp(1, 8, 0), "R5 ping untouched", d, wexp(1, 8, 0));
        bus_read(PONG, d, ds);          chk(d == wexp(2, 6, 0), "R5 pong untouched", d, wexp(2, 6, 0));

        // R6: writing 1 to done does nothing, writing 0 clears; enable bit
        bus_write(PING_ST, 32'h1);
        bus_read(PING_ST, d, ds);       chk(d == 32'd1, "R6 done kept", d, 32'd1);
        bus_write(PING_ST, 32'h8);
        bus_read(PING_ST, d, ds);       chk(d == 32'h8, "R6 clear and enable", d, 32'h8);
        chk(irq == 1'b0, "R7 irq low without done", {31'd0, irq}, 32'd0);

        // R5: drop did not advance the pointer, next frame to ping; R3 partial
        send_frame(3, 3);
        bus_read(PING, d, ds);          chk(d == wexp(3, 3, 0), "R5 pointer held / R3 upper zero", d, wexp(3, 3, 0));
        chk(ds == wexp(3, 3, 0), "R9 single uses ping", ds, wexp(3, 3, 0));
        chk(irq == 1'b1, "R7 irq high", {31'd0, irq}, 32'd1);

        // R11: bus write to data is ignored
        bus_write(PING, 32'hDEADBEEF);
        bus_read(PING, d, ds);          chk(d == wexp(3, 3, 0), "R11 data write ignored", d, wexp(3, 3, 0));

        // R10: completion and clear in the same cycle
        bus_write(PONG_ST, 32'h0);
        bus_read(PONG_ST, d, ds);       chk(d == 32'd0, "R6 pong cleared", d, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rx_valid = 1'b1; rx_byte = bval(7, i); rx_last = (i == 3);
            if (i == 3) begin bus_we = 1'b1; bus_addr = PONG_ST; bus_wdata = 32'h0; end
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0; bus_we = 1'b0; bus_addr = 13'd0;
        bus_read(PONG_ST, d, ds);       chk(d == 32'd1, "R10 set wins", d, 32'd1);
        bus_read(PONG, d, ds);          chk(d == wexp(7, 4, 0), "R10 pong data", d, wexp(7, 4, 0));

        // R8: truncation of an oversize frame into ping
        bus_write(PING_ST, 32'h8);
        send_frame(2050, 5);
        bus_read(PING_ST, d, ds);       chk(d == 32'h9, "R8 status after truncation", d, 32'h9);
        bus_read(PING, d, ds);          chk(d == wexp(5, 2050, 0), "R8 first word", d, wexp(5, 2050, 0));
        bus_read(PING + 13'd2040, d, ds); chk(d == wexp(5, 2044, 510), "R8 last data word", d, wexp(5, 2044, 510));

        // R7: clearing the only enabled done drops irq
        bus_write(PING_ST, 32'h0);
        @(negedge clk);
        chk(irq == 1'b0, "R7 irq after clear", {31'd0, irq}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule